// File: doc/BRIEF.md
# Paired-Page PQ Event State Port

This block is a memory-mapped port that holds two 2-bit PQ event-state fields for each of a set of queue descriptors: one field gates notification and the other gates escalation. Each descriptor occupies two adjacent pages of the address window. The even page reaches the notification field and the odd page reaches the escalation field. The two fields share one decode path but are otherwise independent.

The low twelve address bits select the operation. Depending on the access, it is a trigger, an end-of-interrupt, a query, a set-PQ or an inject. Every operation passes through a fixed PQ state machine. Storage is rewritten only when the state actually changes. When a store asks for the event to be forwarded, a one-cycle notify pulse is raised, carrying the descriptor index and the page. Loads answer one cycle after the request with a 64-bit value. The byte at the lowest address is in bits [63:56], so the numeric value is the bus value.

A separate configuration port loads the valid bit and both PQ fields of one descriptor. It is used for bring-up and test.

Top module: `esb_pq_port`

## Requirements
- R1: The descriptor index is `reqAddr >> (PAGE_SHIFT+1)` and `reqAddr[PAGE_SHIFT]` picks the field (0 notification, 1 escalation). An operation on one field never alters the other field or any other descriptor.
- R2: Only accesses with `reqSize == 8` act. Any other size returns all ones on a load, and on a store it changes nothing and raises no notify.
- R3: A descriptor whose valid bit is 0, or whose index is NUM_DESC or above, returns all ones on every load. A store to it has no effect and raises no notify.
- R4: A store at offset 0x000–0x3FF is a trigger. PQ (P in bit 1, Q in bit 0) moves 00→10 with notify, 01→01, 10→11 and 11→11, and the last three raise no notify.
- R5: A store at offset 0x400–0x7FF is an end-of-interrupt. PQ moves 00→00, 01→01 and 10→00, which raise no notify, and 11→10, which raises a notify.
- R6: A load at offset 0x000–0x7FF applies the same end-of-interrupt transition. It returns 1 when the old PQ was 11 and 0 otherwise, and it never raises a notify.
- R7: A load at offset 0x800–0xBFF returns the PQ in bits [1:0] with zeros above it, and it leaves the state unchanged.
- R8: A load at offset 0xC00–0xFFF sets PQ to offset bits [9:8] and returns the old PQ in bits [1:0].
- R9: A store at offset 0x800–0xBFF is an inject. It raises a notify on the notification page and leaves PQ unchanged. On the escalation page it is rejected, with no notify and no change.
- R10: A store at offset 0xC00–0xFFF has no effect and raises no notify.
- R11: A request is taken on a clock edge while `reqValid` is high. A load's `rspValid` pulses for one cycle after that edge, with `rspData`. A store's notify pulses for one cycle after that edge, with `notifyIdx` and `notifyEsc`. Stores never raise `rspValid`.
- R12: After reset every descriptor is invalid with both PQ fields 00. A `cfgWe` cycle writes the valid bit and both PQ fields of `cfgIdx`, and it takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 store, 0 load |
| reqAddr | input | ADDR_W | Byte address within the window |
| reqSize | input | 4 | Access size in bytes |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | IDX_W | Descriptor to configure |
| cfgValid | input | 1 | Valid bit to load |
| cfgPqNotify | input | 2 | Notification PQ to load |
| cfgPqEscal | input | 2 | Escalation PQ to load |
| rspValid | output | 1 | Load response strobe |
| rspData | output | 64 | Load response value |
| notifyPulse | output | 1 | Forwarding request |
| notifyIdx | output | IDX_W | Descriptor of the forwarding request |
| notifyEsc | output | 1 | Page of the forwarding request (1 escalation) |

## Verification
The assertions check several rules on every cycle. A response follows only a load and a notify follows only a store. A bad-size load reads all ones. End-of-interrupt loads return only 0, 1 or all ones. A query never returns data above bit 1 except the all-ones error value. An escalation-page notify can only come from a trigger or end-of-interrupt offset. The exact PQ transitions, the write-back to the right field, the isolation between pages and descriptors, and the invalid-descriptor behaviour depend on stored state. Only the bench's reference model shows these, using seeded random mixes of operations, directed corner cases and periodic query sweeps.

// File: rtl/esb_pq_pkg.sv
package esb_pq_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI,
    OP_QUERY,
    OP_SET,
    OP_INJECT,
    OP_BAD
  } esbOp_e;

  typedef struct packed {
    logic   fire;
    logic   isLoad;
    logic   sizeOk;
    logic   esc;
    logic [1:0] setVal;
    esbOp_e op;
  } esbStrobe_t;

  // returns {next PQ, forward}
  function automatic logic [2:0] pqTrigger(input logic [1:0] pq);
    case (pq)
      2'b00:   return {2'b10, 1'b1};
      2'b01:   return {2'b01, 1'b0};
      default: return {2'b11, 1'b0};
    endcase
  endfunction

  function automatic logic [2:0] pqEoi(input logic [1:0] pq);
    case (pq)
      2'b00:   return {2'b00, 1'b0};
      2'b01:   return {2'b01, 1'b0};
      2'b10:   return {2'b00, 1'b0};
      default: return {2'b10, 1'b1};
    endcase
  endfunction

endpackage

// File: rtl/esb_pq_ctrl.sv
module esb_pq_ctrl
  import esb_pq_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W = 3,
  parameter int ADDR_W = PAGE_SHIFT + 1 + IDX_W
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqSize,
  output esbStrobe_t        strobe,
  output logic [IDX_W-1:0]  reqIdx
);

  logic [11:0] pageOff;

  assign pageOff = reqAddr[11:0];
  assign reqIdx  = reqAddr[ADDR_W-1:PAGE_SHIFT+1];

  always_comb begin
    strobe        = '0;
    strobe.fire   = reqValid;
    strobe.isLoad = !reqWrite;
    strobe.sizeOk = (reqSize == 4'd8);
    strobe.esc    = reqAddr[PAGE_SHIFT];
    strobe.setVal = pageOff[9:8];
    strobe.op     = OP_NONE;
    if (reqValid) begin
      if (!reqWrite) begin
        if (!pageOff[11])            strobe.op = OP_EOI;
        else if (!pageOff[10])       strobe.op = OP_QUERY;
        else                         strobe.op = OP_SET;
      end else begin
        case (pageOff[11:10])
          2'b00:   strobe.op = OP_TRIG;
          2'b01:   strobe.op = OP_EOI;
          2'b10:   strobe.op = OP_INJECT;
          default: strobe.op = OP_BAD;
        endcase
      end
    end
  end

endmodule

// File: rtl/esb_pq_datapath.sv
module esb_pq_datapath
  import esb_pq_pkg::*;
#(
  parameter int NUM_DESC = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  esbStrobe_t       strobe,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             cfgValid,
  input  logic [1:0]       cfgPqNotify,
  input  logic [1:0]       cfgPqEscal,
  output logic             rspValid,
  output logic [63:0]      rspData,
  output logic             notifyPulse,
  output logic [IDX_W-1:0] notifyIdx,
  output logic             notifyEsc
);

  logic [NUM_DESC-1:0] descValid;
  logic [1:0]          pqNotify [NUM_DESC];
  logic [1:0]          pqEscal  [NUM_DESC];

  logic       selValid;
  logic [1:0] selN, selE, curPq, nxtPq;
  logic       fwd, actOk, wbEn;
  logic [63:0] retVal;

  always_comb begin
    selValid = 1'b0;
    selN     = 2'b00;
    selE     = 2'b00;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (reqIdx == IDX_W'(i)) begin
        selValid = descValid[i];
        selN     = pqNotify[i];
        selE     = pqEscal[i];
      end
    end
  end

  assign curPq = strobe.esc ? selE : selN;
  assign actOk = strobe.fire && strobe.sizeOk && selValid && !cfgWe;

  always_comb begin
    nxtPq  = curPq;
    fwd    = 1'b0;
    retVal = '1;
    case (strobe.op)
      OP_TRIG:   {nxtPq, fwd} = pqTrigger(curPq);
      OP_EOI: begin
        {nxtPq, fwd} = pqEoi(curPq);
        retVal = {63'd0, fwd};
      end
      OP_QUERY:  retVal = {62'd0, curPq};
      OP_SET: begin
        nxtPq  = strobe.setVal;
        retVal = {62'd0, curPq};
      end
      OP_INJECT: fwd = !strobe.esc;
      default: ;
    endcase
  end

  assign wbEn = actOk && (nxtPq != curPq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descValid <= '0;
      for (int i = 0; i < NUM_DESC; i++) begin
        pqNotify[i] <= 2'b00;
        pqEscal[i]  <= 2'b00;
      end
    end else begin
      for (int i = 0; i < NUM_DESC; i++) begin
        if (cfgWe && cfgIdx == IDX_W'(i)) begin
          descValid[i] <= cfgValid;
          pqNotify[i]  <= cfgPqNotify;
          pqEscal[i]   <= cfgPqEscal;
        end else if (wbEn && reqIdx == IDX_W'(i)) begin
          if (strobe.esc) pqEscal[i]  <= nxtPq;
          else            pqNotify[i] <= nxtPq;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspData     <= '0;
      notifyPulse <= 1'b0;
      notifyIdx   <= '0;
      notifyEsc   <= 1'b0;
    end else begin
      rspValid    <= strobe.fire && strobe.isLoad && !cfgWe;
      rspData     <= actOk ? retVal : '1;
      notifyPulse <= actOk && !strobe.isLoad && fwd;
      notifyIdx   <= reqIdx;
      notifyEsc   <= strobe.esc;
    end
  end

endmodule

// File: rtl/esb_pq_port.sv
module esb_pq_port
  import esb_pq_pkg::*;
#(
  parameter int NUM_DESC = 6,
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int ADDR_W = PAGE_SHIFT + 1 + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqSize,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgValid,
  input  logic [1:0]        cfgPqNotify,
  input  logic [1:0]        cfgPqEscal,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic              notifyPulse,
  output logic [IDX_W-1:0]  notifyIdx,
  output logic              notifyEsc
);

  esbStrobe_t       strobe;
  logic [IDX_W-1:0] reqIdx;

  esb_pq_ctrl #(.PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .strobe(strobe), .reqIdx(reqIdx)
  );

  esb_pq_datapath #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIdx(reqIdx),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgValid(cfgValid),
    .cfgPqNotify(cfgPqNotify), .cfgPqEscal(cfgPqEscal),
    .rspValid(rspValid), .rspData(rspData),
    .notifyPulse(notifyPulse), .notifyIdx(notifyIdx), .notifyEsc(notifyEsc)
  );

endmodule

// File: rtl/esb_pq_chk.sv
module esb_pq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [3:0]        reqSize,
  input logic              cfgWe,
  input logic              rspValid,
  input logic [63:0]       rspData,
  input logic              notifyPulse,
  input logic              notifyEsc
);

  // R11
  rsp_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite));

  // R11
  notify_after_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    notifyPulse |-> $past(reqValid && reqWrite && !cfgWe));

  // R2
  bad_size_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqSize) != 4'd8) |-> (rspData == '1));

  // R9
  esc_notify_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (notifyPulse && notifyEsc) |-> ($past(reqAddr[11:0]) < 12'h800));

  // R6
  load_eoi_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqAddr[11:0]) < 12'h800) |->
      (rspData == 64'd0 || rspData == 64'd1 || rspData == '1));

  // R7
  query_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqAddr[11:10]) == 2'b10) |->
      (rspData[63:2] == 62'd0 || rspData == '1));

endmodule

bind esb_pq_port esb_pq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqSize(reqSize), .cfgWe(cfgWe),
  .rspValid(rspValid), .rspData(rspData),
  .notifyPulse(notifyPulse), .notifyEsc(notifyEsc)
);

// File: tb/tb_esb_pq_port.sv
`timescale 1ns/1ps
module tb_esb_pq_port;

  localparam int NUM_DESC = 6;
  localparam int PS = 12;
  localparam int IDX_W = 3;
  localparam int ADDR_W = PS + 1 + IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [3:0] reqSize = 4'd8;
  logic cfgWe = 1'b0, cfgValid = 1'b0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [1:0] cfgPqNotify = 2'b00, cfgPqEscal = 2'b00;
  logic rspValid, notifyPulse, notifyEsc;
  logic [63:0] rspData;
  logic [IDX_W-1:0] notifyIdx;

  always #4 clk = ~clk;

  esb_pq_port #(.NUM_DESC(NUM_DESC), .PAGE_SHIFT(PS)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgValid(cfgValid), .cfgPqNotify(cfgPqNotify), .cfgPqEscal(cfgPqEscal),
    .rspValid(rspValid), .rspData(rspData), .notifyPulse(notifyPulse),
    .notifyIdx(notifyIdx), .notifyEsc(notifyEsc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit       refValid [8];
  bit [1:0] refN [8];
  bit [1:0] refE [8];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input bit w, input bit [1:0] pq, input bit esc,
                                input bit [11:0] off, output bit [1:0] nxt,
                                output bit fwd, output bit [63:0] ret);
    bit n;
    nxt = pq; fwd = 0; ret = '1; n = 0;
    if (!w) begin
      if (off < 12'h800) begin
        case (pq) 2'b10: nxt = 2'b00; 2'b11: begin nxt = 2'b10; n = 1; end default: ; endcase
        ret = {63'd0, n};
      end else if (off < 12'hC00) ret = {62'd0, pq};
      else begin nxt = off[9:8]; ret = {62'd0, pq}; end
    end else begin
      if (off < 12'h400) begin
        if (pq == 2'b00) begin nxt = 2'b10; fwd = 1; end else nxt = 2'b11 & (pq == 2'b01 ? 2'b01 : 2'b11);
      end else if (off < 12'h800) begin
        case (pq) 2'b10: nxt = 2'b00; 2'b11: begin nxt = 2'b10; fwd = 1; end default: ; endcase
      end else if (off < 12'hC00) fwd = !esc;
    end
  endfunction

  task automatic access(input bit w, input int idx, input bit esc, input bit [11:0] off,
                        input bit [3:0] size, input string req);
    bit [1:0] cur, nxt;
    bit fwd, ok;
    bit [63:0] ret;
    ok = (size == 4'd8) && idx < NUM_DESC && refValid[idx];
    cur = esc ? refE[idx] : refN[idx];
    model(w, cur, esc, off, nxt, fwd, ret);
    if (!ok) begin nxt = cur; fwd = 0; ret = '1; end
    @(negedge clk);
    reqValid = 1; reqWrite = w; reqSize = size;
    reqAddr = {IDX_W'(idx), esc, off};
    @(negedge clk);
    reqValid = 0;
    if (!w) begin
      check({req, " rspValid"}, {63'd0, rspValid}, 64'd1);
      check({req, " rspData"}, rspData, ret);
      check({req, " no notify on load"}, {63'd0, notifyPulse}, 64'd0);
    end else begin
      check({req, " no rsp on store"}, {63'd0, rspValid}, 64'd0);
      check({req, " notify"}, {63'd0, notifyPulse}, {63'd0, fwd});
      if (fwd) check({req, " notify idx/page"}, {60'd0, notifyIdx, notifyEsc},
                     {60'd0, IDX_W'(idx), esc});
    end
    if (esc) refE[idx] = nxt; else refN[idx] = nxt;
  endtask

  task automatic cfg(input int idx, input bit v, input bit [1:0] n, input bit [1:0] e);
    @(negedge clk);
    cfgWe = 1; cfgIdx = IDX_W'(idx); cfgValid = v; cfgPqNotify = n; cfgPqEscal = e;
    @(negedge clk);
    cfgWe = 0;
    refValid[idx] = v; refN[idx] = n; refE[idx] = e;
  endtask

  task automatic sweep();
    for (int i = 0; i < 8; i++) begin
      access(0, i, 0, 12'h800, 8, "R1 R3 sweep notify");
      access(0, i, 1, 12'h9F8, 8, "R1 R3 sweep escal");
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL R11 watchdog actual=%0d expected<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin refValid[i] = 0; refN[i] = 0; refE[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R12 reset rspValid", {63'd0, rspValid}, 64'd0);
    check("R12 reset notify", {63'd0, notifyPulse}, 64'd0);
    access(0, 0, 0, 12'h800, 8, "R12 reset invalid");
    cfg(0, 1, 2'b00, 2'b00);
    access(0, 0, 0, 12'h800, 8, "R12 cfg query");
    // trigger walk
    access(1, 0, 0, 12'h000, 8, "R4 trig 00");
    access(1, 0, 0, 12'h3F8, 8, "R4 trig 10");
    access(1, 0, 0, 12'h100, 8, "R4 trig 11");
    access(0, 0, 1, 12'h800, 8, "R1 escal untouched");
    access(1, 0, 0, 12'h400, 8, "R5 eoi 11");
    access(1, 0, 0, 12'h7F8, 8, "R5 eoi 10");
    access(1, 0, 0, 12'h500, 8, "R5 eoi 00");
    access(0, 0, 0, 12'hD00, 8, "R8 set 01");
    access(1, 0, 0, 12'h000, 8, "R4 trig 01");
    access(1, 0, 0, 12'h400, 8, "R5 eoi 01");
    access(0, 0, 0, 12'hF00, 8, "R8 set 11");
    access(0, 0, 0, 12'h000, 8, "R6 load eoi 11");
    access(0, 0, 0, 12'h7F8, 8, "R6 load eoi 10");
    access(1, 0, 0, 12'h800, 8, "R9 inject notify");
    access(1, 0, 1, 12'h800, 8, "R9 inject escal rejected");
    access(1, 0, 1, 12'h000, 8, "R4 trig escal");
    access(1, 0, 0, 12'hC00, 8, "R10 store undefined");
    access(0, 0, 0, 12'h800, 4, "R2 bad size load");
    access(1, 0, 1, 12'h000, 4, "R2 bad size store");
    access(1, 6, 0, 12'h000, 8, "R3 out of range");
    cfg(1, 0, 2'b00, 2'b00);
    access(1, 1, 0, 12'h000, 8, "R3 invalid store");
    for (int i = 0; i < NUM_DESC; i++) cfg(i, ($urandom % 5) != 0, 2'($urandom), 2'($urandom));
    sweep();
    for (int n = 0; n < 1500; n++) begin
      int idx;
      bit w, esc;
      bit [11:0] off;
      bit [3:0] sz;
      idx = $urandom % 8;
      w = $urandom % 2;
      esc = $urandom % 2;
      off = {2'($urandom), 7'($urandom), 3'b000};
      sz = (($urandom % 10) == 0) ? 4'd4 : 4'd8;
      access(w, idx, esc, off, sz, "R1 R4 R5 R6 R7 R8 R9 R10 random");
      if (n % 100 == 99) sweep();
      if (n % 400 == 399) cfg($urandom % NUM_DESC, 1, 2'($urandom), 2'($urandom));
    end
    sweep();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule